// File: doc/BRIEF.md
# Switch Address Lookup Table

This block keeps a small, fixed-depth table of forwarding entries for an Ethernet switch and answers destination-address queries against it. Software never touches an entry directly: it fills three 32-bit staging words and then writes a table-control register. That write either copies the staging words into the chosen entry or copies the entry back into the staging words. Each entry is 68 bits of defined fields, plus one extra top bit that extends the multicast port mask to three ports. The staging words present these bits high word first. A global control register enables the table, clears it in one write and holds a VLAN-aware mode bit. One state register per switch port records whether that port may forward.

A lookup request carries a 48-bit destination MAC address. The block scans the entries in index order, one per clock, and stops at the first address entry whose address matches. It then returns a forward result with the egress port mask, a drop result, or a miss result, together with a one-cycle done strobe. A unicast match forwards to a single port. A multicast match forwards to every port in its mask that is currently in the forwarding state.

Top module: `addr_lookup_table`

## Requirements
- R1: Entry bit n is held in staging word 2 − n/32 at bit n mod 32. Word 0 (register 4) holds bits 95:64, word 1 (register 5) holds bits 63:32, and word 2 (register 6) holds bits 31:0. All three words are readable and writable. Bits above the stored entry width (bit 68) read back as zero after a table read.
- R2: Register 1 is table control, and the entry index sits in its low 4 bits. Writing it with bit 31 set stores the staging words into that entry. Writing it with bit 31 clear loads that entry into the staging words. The register reads back the last index with bit 31 zero.
- R3: Register 0 is global control. Bit 31 enables the table and bit 2 selects VLAN-aware mode; both read back as written. Writing bit 30 as one sets every entry to all zeros, which makes it free (type 0). Bit 30 always reads as zero.
- R4: Registers 8, 9 and 10 hold the 2-bit state of ports 0, 1 and 2: 0 disabled, 1 blocking, 2 learning, 3 forwarding. The upper 30 bits read as zero.
- R5: With the table enabled, a lookup examines entry k in the (k+1)-th clock after the request. It stops at the first entry whose type field (bits 61:60) is 1 (address) or 3 (VLAN plus address) and whose bits 47:0 equal the request address. Types 0 and 2 never match. A hit at index k raises done k+2 clock edges after the request edge. A miss raises done after 17 edges with result 0 (miss), mask 0 and index 0.
- R6: A unicast match (bit 40 clear) gives result 1 (forward) with a one-hot mask of the port in bits 67:66. This happens only when that port exists and its state is 3. Otherwise, or when the blocked bit 65 is set, it gives result 2 (drop) with mask 0. The index output gives the matched entry.
- R7: A multicast match (bit 40 set) takes the port mask in bits 68:66, bit 66 being port 0, and keeps only the ports whose state is 3. A non-empty set gives result 1 with that set as the mask. An empty set gives result 2 with mask 0.
- R8: While the table is disabled, a request completes one clock edge later with result 0 and mask 0 and does not scan.
- R9: A request while a scan is busy is ignored. The running scan finishes with the result for its own address.
- R10: Table writes and clears take effect at once during a scan. An entry is judged by the contents it holds in the cycle the scan examines it.
- R11: After reset, every register and staging word reads zero, every entry is free, and done and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| lk_req | input | 1 | Start a lookup (taken only when idle) |
| lk_mac | input | 48 | Destination address to look up |
| lk_busy | output | 1 | Scan in progress |
| lk_done | output | 1 | One-cycle strobe: result outputs valid |
| lk_result | output | 2 | 0 miss, 1 forward, 2 drop |
| lk_mask | output | 3 | Egress port mask on forward, else zero |
| lk_index | output | 4 | Index of the matched entry, zero on miss |

## Verification
The two functions that can share a clock edge are a table write through the register interface and a lookup scan. The bench provokes this by loading the staging words in advance and then driving a table-control write on the same edge that the lookup request is taken. The write targets an entry the scan has not yet reached, so the expected result must come from the new contents. The bench also holds the request high through the first scan cycle with a different address. That result is judged against a reference model which updates its own table at the write edge and ignores the second request.

// File: rtl/alut_pkg.sv
package alut_pkg;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned N_WORDS     = 3;
   localparam int unsigned STAGE_W     = WORD_W * N_WORDS;
   localparam int unsigned MAC_W       = 48;
   localparam int unsigned BIT_MCAST   = 40;
   localparam int unsigned TYPE_LO     = 60;
   localparam int unsigned AGE_LO      = 62;
   localparam int unsigned BIT_SECURE  = 64;
   localparam int unsigned BIT_BLOCKED = 65;
   localparam int unsigned PORT_LO     = 66;
   localparam int unsigned PORT_NUM_W  = 2;
   localparam int unsigned BASE_ENT_W  = 68;

   localparam int unsigned TCTL_WR_BIT   = 31;
   localparam int unsigned GCTL_EN_BIT   = 31;
   localparam int unsigned GCTL_CLR_BIT  = 30;
   localparam int unsigned GCTL_VLAN_BIT = 2;

   localparam logic [3:0] RA_GCTL    = 4'h0;
   localparam logic [3:0] RA_TCTL    = 4'h1;
   localparam logic [3:0] RA_STAGE0  = 4'h4;
   localparam logic [3:0] RA_PSTATE0 = 4'h8;

   typedef enum logic [1:0] {
      ET_FREE  = 2'd0,
      ET_ADDR  = 2'd1,
      ET_VLAN  = 2'd2,
      ET_VADDR = 2'd3
   } ent_type_e;

   typedef enum logic [1:0] {
      PS_DISABLED = 2'd0,
      PS_BLOCKING = 2'd1,
      PS_LEARNING = 2'd2,
      PS_FORWARD  = 2'd3
   } port_state_e;

   typedef enum logic [1:0] {
      LK_MISS = 2'd0,
      LK_FWD  = 2'd1,
      LK_DROP = 2'd2
   } lk_res_e;
endpackage

// File: rtl/alut_store.sv
module alut_store #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned ENT_W = 69
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ENT_W-1:0] wr_data,
   input  logic             clr_all,
   input  logic [IDX_W-1:0] rd_idx_a,
   input  logic [IDX_W-1:0] rd_idx_b,
   output logic [ENT_W-1:0] rd_a,
   output logic [ENT_W-1:0] rd_b
);
   logic [ENT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr_all) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   assign rd_a = mem[rd_idx_a];
   assign rd_b = mem[rd_idx_b];

   // R3: a clear leaves entry 0 free on the next cycle
   p_clear_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (mem[0] == '0));
endmodule

// File: rtl/alut_regs.sv
module alut_regs
   import alut_pkg::*;
#(
   parameter int unsigned NPORTS = 3,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned ENT_W  = 69
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic [ENT_W-1:0]  ent_rd,
   output logic [IDX_W-1:0]  tbl_idx,
   output logic              tbl_wr,
   output logic [ENT_W-1:0]  tbl_wdata,
   output logic              tbl_clr,
   output logic              tbl_en,
   output logic [NPORTS-1:0] port_fwd
);
   localparam logic [3:0] RA_PLAST = RA_PSTATE0 + 4'(NPORTS - 1);

   logic [WORD_W-1:0]  stage [N_WORDS];
   logic [STAGE_W-1:0] stage_flat;
   logic [IDX_W-1:0]   tctl_idx;
   logic               en_q, vlan_q;
   logic [1:0]         pstate [NPORTS];
   logic               wr_tctl, wr_gctl;

   assign wr_tctl = cfg_we && (cfg_addr == RA_TCTL);
   assign wr_gctl = cfg_we && (cfg_addr == RA_GCTL);

   assign tbl_idx   = cfg_wdata[IDX_W-1:0];
   assign tbl_wr    = wr_tctl && cfg_wdata[TCTL_WR_BIT];
   assign tbl_clr   = wr_gctl && cfg_wdata[GCTL_CLR_BIT];
   assign tbl_en    = en_q;
   assign stage_flat = {stage[0], stage[1], stage[2]};
   assign tbl_wdata = stage_flat[ENT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < N_WORDS; w++) stage[w] <= '0;
         tctl_idx <= '0;
         en_q     <= 1'b0;
         vlan_q   <= 1'b0;
      end else if (cfg_we) begin
         if (wr_gctl) begin
            en_q   <= cfg_wdata[GCTL_EN_BIT];
            vlan_q <= cfg_wdata[GCTL_VLAN_BIT];
         end
         if (wr_tctl) begin
            tctl_idx <= cfg_wdata[IDX_W-1:0];
            if (!cfg_wdata[TCTL_WR_BIT]) begin
               for (int w = 0; w < N_WORDS; w++)
                  stage[w] <= STAGE_W'(ent_rd) >> (WORD_W * (N_WORDS - 1 - w));
            end
         end
         for (int w = 0; w < N_WORDS; w++)
            if (cfg_addr == RA_STAGE0 + 4'(w)) stage[w] <= cfg_wdata;
      end
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pstate[p] <= PS_DISABLED;
         else if (cfg_we && cfg_addr == RA_PSTATE0 + 4'(p)) pstate[p] <= cfg_wdata[1:0];
      end
      assign port_fwd[p] = (pstate[p] == PS_FORWARD);
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == RA_GCTL) begin
         cfg_rdata[GCTL_EN_BIT]   = en_q;
         cfg_rdata[GCTL_VLAN_BIT] = vlan_q;
      end else if (cfg_addr == RA_TCTL) begin
         cfg_rdata[IDX_W-1:0] = tctl_idx;
      end else if (cfg_addr >= RA_STAGE0 && cfg_addr < RA_STAGE0 + 4'(N_WORDS)) begin
         cfg_rdata = stage[2'(cfg_addr - RA_STAGE0)];
      end else if (cfg_addr >= RA_PSTATE0 && cfg_addr <= RA_PLAST) begin
         for (int p = 0; p < NPORTS; p++)
            if (cfg_addr == RA_PSTATE0 + 4'(p)) cfg_rdata[1:0] = pstate[p];
      end
   end

   // R3: the clear bit is a command and never reads back as one
   p_clr_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == RA_GCTL) |-> !cfg_rdata[GCTL_CLR_BIT]);
endmodule

// File: rtl/alut_scan.sv
module alut_scan
   import alut_pkg::*;
#(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned NPORTS = 3,
   parameter int unsigned ENT_W  = 69
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [MAC_W-1:0]  mac,
   input  logic              en,
   input  logic [NPORTS-1:0] port_fwd,
   input  logic [ENT_W-1:0]  ent,
   output logic [IDX_W-1:0]  idx,
   output logic              busy,
   output logic              done,
   output logic [1:0]        res,
   output logic [NPORTS-1:0] mask,
   output logic [IDX_W-1:0]  hit_idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic [MAC_W-1:0]      mac_q;
   logic [1:0]            etype;
   logic                  match, is_mc, blocked;
   logic [PORT_NUM_W-1:0] pnum;
   logic [NPORTS-1:0]     uc_mask, mc_mask;
   logic [1:0]            hit_res;
   logic [NPORTS-1:0]     hit_mask;
   logic [3:0]            unused_bits;

   assign etype   = ent[TYPE_LO +: 2];
   assign is_mc   = ent[BIT_MCAST];
   assign blocked = ent[BIT_BLOCKED];
   assign pnum    = ent[PORT_LO +: PORT_NUM_W];
   assign match   = ((etype == ET_ADDR) || (etype == ET_VADDR)) &&
                    (ent[MAC_W-1:0] == mac_q);
   assign mc_mask = ent[PORT_LO +: NPORTS] & port_fwd;
   assign unused_bits = {ent[AGE_LO +: 2], ent[BIT_SECURE], 1'b0};

   always_comb begin
      uc_mask = '0;
      for (int p = 0; p < NPORTS; p++)
         if (pnum == PORT_NUM_W'(p)) uc_mask[p] = 1'b1;
   end

   always_comb begin
      hit_res  = LK_DROP;
      hit_mask = '0;
      if (is_mc) begin
         if (|mc_mask) begin
            hit_res  = LK_FWD;
            hit_mask = mc_mask;
         end
      end else if (!blocked && |(uc_mask & port_fwd)) begin
         hit_res  = LK_FWD;
         hit_mask = uc_mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         idx     <= '0;
         mac_q   <= '0;
         res     <= LK_MISS;
         mask    <= '0;
         hit_idx <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (req) begin
               if (!en) begin
                  done    <= 1'b1;
                  res     <= LK_MISS;
                  mask    <= '0;
                  hit_idx <= '0;
               end else begin
                  busy  <= 1'b1;
                  idx   <= '0;
                  mac_q <= mac;
               end
            end
         end else if (match) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            res     <= hit_res;
            mask    <= hit_mask;
            hit_idx <= idx;
         end else if (idx == LAST) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            res     <= LK_MISS;
            mask    <= '0;
            hit_idx <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R5: a scan only ever starts from a request
   p_start_on_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req));
   // R5: the result code is one of the three defined values
   p_res_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (res != 2'd3));
   // R9: the scan is idle whenever a result is presented
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R6: non-forward results carry an empty mask
   p_mask_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res != LK_FWD) |-> (mask == '0));
endmodule

// File: rtl/addr_lookup_table.sv
module addr_lookup_table
   import alut_pkg::*;
#(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned NPORTS = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [3:0]               cfg_addr,
   input  logic [31:0]              cfg_wdata,
   output logic [31:0]              cfg_rdata,
   input  logic                     lk_req,
   input  logic [47:0]              lk_mac,
   output logic                     lk_busy,
   output logic                     lk_done,
   output logic [1:0]               lk_result,
   output logic [NPORTS-1:0]        lk_mask,
   output logic [$clog2(DEPTH)-1:0] lk_index
);
   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam int unsigned ENT_W = (PORT_LO + NPORTS > BASE_ENT_W) ?
                                   (PORT_LO + NPORTS) : BASE_ENT_W;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (IDX_W > 30) begin : g_bad_idx
      $error("index does not fit the table-control register");
   end
   if (NPORTS < 2 || NPORTS > 4) begin : g_bad_ports
      $error("NPORTS must lie in 2..4");
   end

   logic [IDX_W-1:0]  tbl_idx, scan_idx;
   logic              tbl_wr, tbl_clr, tbl_en;
   logic [ENT_W-1:0]  tbl_wdata, ent_scan, ent_cfg;
   logic [NPORTS-1:0] port_fwd;

   alut_regs #(.NPORTS(NPORTS), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .ent_rd(ent_cfg),
      .tbl_idx(tbl_idx), .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata),
      .tbl_clr(tbl_clr), .tbl_en(tbl_en), .port_fwd(port_fwd)
   );

   alut_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_wr), .wr_idx(tbl_idx), .wr_data(tbl_wdata),
      .clr_all(tbl_clr),
      .rd_idx_a(scan_idx), .rd_idx_b(tbl_idx),
      .rd_a(ent_scan), .rd_b(ent_cfg)
   );

   alut_scan #(.DEPTH(DEPTH), .IDX_W(IDX_W), .NPORTS(NPORTS), .ENT_W(ENT_W)) u_scan (
      .clk(clk), .rst_n(rst_n),
      .req(lk_req), .mac(lk_mac), .en(tbl_en), .port_fwd(port_fwd),
      .ent(ent_scan), .idx(scan_idx),
      .busy(lk_busy), .done(lk_done), .res(lk_result),
      .mask(lk_mask), .hit_idx(lk_index)
   );

   // R6 R7: every port in a forward mask was forwarding when the entry was judged
   p_fwd_ports_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && lk_result == LK_FWD) |-> ((lk_mask & ~$past(port_fwd)) == '0));
endmodule

// File: tb/addr_lookup_table_bench.sv
`timescale 1ns/1ps
module addr_lookup_table_bench;
   localparam int DEPTH  = 16;
   localparam int NPORTS = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        lk_req = 1'b0;
   logic [47:0] lk_mac = '0;
   logic        lk_busy, lk_done;
   logic [1:0]  lk_result;
   logic [2:0]  lk_mask;
   logic [3:0]  lk_index;

   always #4 clk = ~clk;

   addr_lookup_table #(.DEPTH(DEPTH), .NPORTS(NPORTS)) u_addr_lookup_table (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_req(lk_req),
      .lk_mac(lk_mac), .lk_busy(lk_busy), .lk_done(lk_done),
      .lk_result(lk_result), .lk_mask(lk_mask), .lk_index(lk_index)
   );

   int checks = 0;
   int fails  = 0;

   // reference state
   logic [95:0] ref_mem [DEPTH];
   logic [31:0] ref_stage [3];
   logic [1:0]  ref_ps [NPORTS];
   logic        ref_en = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [95:0] mk_uc(logic [1:0] ty, logic [47:0] mac, logic [1:0] port, logic blk);
      logic [95:0] e = '0;
      e[47:0] = mac; e[61:60] = ty; e[65] = blk; e[67:66] = port;
      return e;
   endfunction

   function automatic logic [95:0] mk_mc(logic [47:0] mac, logic [2:0] m);
      logic [95:0] e = '0;
      e[47:0] = mac; e[61:60] = 2'd1; e[63:62] = 2'd3; e[68:66] = m;
      return e;
   endfunction

   function automatic void apply_write(logic [3:0] a, logic [31:0] d);
      if (a == 4'h0) begin
         ref_en = d[31];
         if (d[30]) for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      end else if (a == 4'h1) begin
         if (d[31]) ref_mem[d[3:0]] = {ref_stage[0], ref_stage[1], ref_stage[2]} & {27'd0, {69{1'b1}}};
         else {ref_stage[0], ref_stage[1], ref_stage[2]} = ref_mem[d[3:0]];
      end else if (a >= 4'h4 && a <= 4'h6) begin
         ref_stage[a - 4'h4] = d;
      end else if (a >= 4'h8 && a < 4'h8 + NPORTS) begin
         ref_ps[a - 4'h8] = d[1:0];
      end
   endfunction

   function automatic void ref_look(input logic [47:0] mac, output int res, output int msk,
                                    output int idx, output int lat);
      res = 0; msk = 0; idx = 0;
      if (!ref_en) begin lat = 1; return; end
      lat = DEPTH + 1;
      for (int k = 0; k < DEPTH; k++) begin
         logic [95:0] e = ref_mem[k];
         if ((e[61:60] == 2'd1 || e[61:60] == 2'd3) && e[47:0] == mac) begin
            idx = k; lat = k + 2; res = 2;
            if (e[40]) begin
               for (int p = 0; p < NPORTS; p++)
                  if (e[66 + p] && ref_ps[p] == 2'd3) msk |= (1 << p);
               if (msk != 0) res = 1;
            end else if (!e[65] && e[67:66] < NPORTS && ref_ps[e[67:66]] == 2'd3) begin
               res = 1; msk = 1 << e[67:66];
            end
            return;
         end
      end
   endfunction

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      apply_write(a, d);
   endtask

   task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
      cfg_addr = a;
      #1;
      check(cfg_rdata === exp, tag, {64'd0, cfg_rdata}, {64'd0, exp});
   endtask

   task automatic load_entry(input int idx, input logic [95:0] e);
      wr(4'h4, e[95:64]); wr(4'h5, e[63:32]); wr(4'h6, e[31:0]);
      wr(4'h1, 32'h8000_0000 | idx);
   endtask

   // per-clock comparison of busy/done against the model; side_idx >= 0 adds a
   // table write on the request edge; hold keeps the request high one more edge
   task automatic lookup(input logic [47:0] mac, input int side_idx, input bit hold,
                         input logic [47:0] other, input string tag);
      int res, msk, idx, lat;
      @(negedge clk);
      lk_req = 1'b1; lk_mac = mac;
      if (side_idx >= 0) begin
         cfg_we = 1'b1; cfg_addr = 4'h1; cfg_wdata = 32'h8000_0000 | side_idx;
         apply_write(4'h1, cfg_wdata);
      end
      ref_look(mac, res, msk, idx, lat);
      for (int n = 1; n <= lat; n++) begin
         @(negedge clk);
         cfg_we = 1'b0;
         if (n == 1 && hold) lk_mac = other; else lk_req = 1'b0;
         if (n == 2) lk_req = 1'b0;
         check(lk_done === (n == lat), {tag, " done timing"}, {95'd0, lk_done}, {95'd0, n == lat});
         check(lk_busy === (ref_en && n < lat), {tag, " busy"}, {95'd0, lk_busy}, {95'd0, ref_en && n < lat});
         if (n == lat) begin
            check(lk_result === 2'(res), {tag, " result"}, {94'd0, lk_result}, 96'(res));
            check(lk_mask === 3'(msk), {tag, " mask"}, {93'd0, lk_mask}, 96'(msk));
            check(lk_index === 4'(idx), {tag, " index"}, {92'd0, lk_index}, 96'(idx));
         end
      end
      lk_req = 1'b0;
   endtask

   localparam logic [47:0] MAC_A = 48'h0200_0000_00A1;
   localparam logic [47:0] MAC_B = 48'h0200_0000_00B2;
   localparam logic [47:0] MAC_C = 48'h0200_0000_00C3;
   localparam logic [47:0] MAC_D = 48'h0200_0000_00D4;
   localparam logic [47:0] MAC_E = 48'h0200_0000_00E5;
   localparam logic [47:0] MAC_F = 48'h0100_5E00_0001;
   localparam logic [47:0] MAC_G = 48'h0100_5E00_0002;
   localparam logic [47:0] MAC_H = 48'h0200_0000_0077;
   localparam logic [47:0] MAC_J = 48'h0200_0000_0099;

   bit finished = 1'b0;

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      for (int w = 0; w < 3; w++) ref_stage[w] = '0;
      for (int p = 0; p < NPORTS; p++) ref_ps[p] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      rd_check(4'h0, 32'h0, "R11 gctl");
      rd_check(4'h1, 32'h0, "R11 tctl");
      rd_check(4'h5, 32'h0, "R11 stage1");
      rd_check(4'h9, 32'h0, "R11 pstate1");
      check(lk_done === 1'b0 && lk_busy === 1'b0, "R11 done/busy", {94'd0, lk_done, lk_busy}, 96'd0);

      // R1 staging words
      wr(4'h4, 32'h1111_0004); wr(4'h5, 32'h2222_0005); wr(4'h6, 32'h3333_0006);
      rd_check(4'h4, 32'h1111_0004, "R1 stage0");
      rd_check(4'h5, 32'h2222_0005, "R1 stage1");
      rd_check(4'h6, 32'h3333_0006, "R1 stage2");

      // R4 port state
      wr(4'h8, 32'hFFFF_FFFF);
      rd_check(4'h8, 32'h3, "R4 upper bits zero");
      wr(4'h9, 32'h3); wr(4'hA, 32'h1);
      rd_check(4'hA, 32'h1, "R4 blocking");

      // R3 enable + vlan mode
      wr(4'h0, 32'h8000_0004);
      rd_check(4'h0, 32'h8000_0004, "R3 gctl readback");

      // table contents
      load_entry(0, mk_uc(2'd0, MAC_A, 2'd0, 1'b0));
      load_entry(2, mk_uc(2'd2, MAC_A, 2'd0, 1'b0));
      load_entry(3, mk_uc(2'd1, MAC_A, 2'd1, 1'b0));
      load_entry(5, mk_uc(2'd1, MAC_A, 2'd0, 1'b0));
      load_entry(4, mk_uc(2'd1, MAC_B, 2'd0, 1'b1));
      load_entry(6, mk_uc(2'd1, MAC_C, 2'd2, 1'b0));
      load_entry(7, mk_uc(2'd1, MAC_D, 2'd3, 1'b0));
      load_entry(8, mk_uc(2'd3, MAC_E, 2'd0, 1'b0));
      load_entry(9, mk_mc(MAC_F, 3'b111));
      load_entry(11, mk_mc(MAC_G, 3'b100));

      // R2 table read back through staging, bit 31 reads zero
      wr(4'h4, 32'h0); wr(4'h1, 32'h0000_0003);
      rd_check(4'h1, 32'h3, "R2 tctl readback");
      rd_check(4'h4, 32'h0000_0004, "R2 R1 word0 holds bits 95:64");
      rd_check(4'h5, 32'h1000_0200, "R2 R1 word1 holds bits 63:32");
      rd_check(4'h6, 32'h0000_00A1, "R2 word2 holds bits 31:0");

      lookup(MAC_A, -1, 1'b0, '0, "R5 first match skips free and vlan");
      lookup(MAC_B, -1, 1'b0, '0, "R6 blocked drop");
      lookup(MAC_C, -1, 1'b0, '0, "R6 port not forwarding");
      lookup(MAC_D, -1, 1'b0, '0, "R6 port out of range");
      lookup(MAC_E, -1, 1'b0, '0, "R5 R6 vlan+addr type forwards");
      lookup(MAC_F, -1, 1'b0, '0, "R7 multicast masked");
      lookup(MAC_G, -1, 1'b0, '0, "R7 multicast empty drop");
      lookup(MAC_H, -1, 1'b0, '0, "R5 miss");
      lookup(MAC_A, -1, 1'b1, MAC_F, "R9 request while busy");

      // R10 write on the request edge to an entry not yet scanned
      wr(4'h4, 32'h0000_0004); wr(4'h5, 32'h1000_0200); wr(4'h6, 32'h0000_0099);
      lookup(MAC_J, 12, 1'b0, '0, "R10 write during scan");

      // R3 clear
      wr(4'h0, 32'hC000_0000);
      rd_check(4'h0, 32'h8000_0000, "R3 clear bit reads zero");
      lookup(MAC_A, -1, 1'b0, '0, "R3 cleared table misses");
      wr(4'h1, 32'h0000_0003);
      rd_check(4'h6, 32'h0, "R3 entry freed");

      // R8 disabled table
      load_entry(1, mk_uc(2'd1, MAC_A, 2'd0, 1'b0));
      wr(4'h0, 32'h0);
      lookup(MAC_A, -1, 1'b0, '0, "R8 disabled");

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule